// File: doc/BRIEF.md
# Predictive Counter-Based Clock-Domain Synchronizer

This block carries one bit from a transmit clock domain into a receive clock domain whose clock has a fixed rational period relation to the transmit clock and only bounded jitter. Under those conditions, the receive edges that can land close to a transmit edge recur at a fixed cycle interval. A modulo counter in the receive domain predicts them. On those predicted danger cycles the output comes from a two-flop synchronizer path. On every other cycle it comes from the first capture flop, so the data arrives one receive cycle earlier.

The counter is phase-locked to the clock beat pattern by an alignment detector. A toggle flop in the transmit domain inverts on every transmit edge and is brought out as `align_tgl`. Outside the block, two copies of that toggle are delayed by different amounts and return as `align_early` and `align_late`. These copies are the two sampling points, spaced wider than the combined jitter. When the two receive-side sample flops disagree, the counter restarts. Until the first restart the block stays on the two-flop path. The period and the danger phase can both be set at run time.

Top module: `predictive_sync`

## Requirements
- R1: Before the first alignment restart since reset, `sync_sel` is 1 on every cycle and `dout` follows the two-flop path.
- R2: `align_tgl` is 0 while `tx_rst_n` is low and inverts on every transmit edge afterwards. After a receive edge at which the registered samples of `align_early` and `align_late` differ, the counter restarts at the next edge, provided `align_en` is 1 there. At that edge the count becomes 1 and `aligned` rises. `aligned` then stays 1 until reset.
- R3: With no restart, the count advances by one per receive edge. It wraps to 0 after reaching period−1. `sync_sel` is 1 after exactly those edges at which the count equals the effective phase.
- R4: When `sync_sel` is 0, `dout` equals the value of `tx_bit` sampled at the most recent receive edge, which is a latency of one receive cycle.
- R5: When `sync_sel` is 1, `dout` equals `tx_bit` as sampled one receive edge earlier, taken through the second flop. The value captured at the latest edge never reaches `dout` on that cycle.
- R6: The effective period is mapped from `period_cfg` as follows: code 0 selects 4, code 1 selects 2, codes above 16 select 16, and codes 2 to 16 are used as given.
- R7: A `phase_cfg` value above period−1 acts as period−1.
- R8: While `rx_rst_n` is low at a receive edge, the count, both capture flops and both alignment sample flops clear. After such an edge, `aligned` is 0, `sync_sel` is 1 and `dout` is 0.
- R9: Consider a design that is aligned with phase 0 at the true beat period. An unknown value on `tx_bit` at a danger edge never appears on `dout`.
- R10: While `align_en` is 0, a sample disagreement causes no restart, and the count keeps running freely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Receive clock |
| rx_rst_n | input | 1 | Active-low synchronous reset, receive domain |
| tx_clk | input | 1 | Transmit clock |
| tx_rst_n | input | 1 | Active-low synchronous reset, transmit domain |
| tx_bit | input | 1 | Data bit launched in the transmit domain |
| align_en | input | 1 | Allows sample disagreements to restart the counter |
| period_cfg | input | CFG_W (5) | Danger period code |
| phase_cfg | input | CNT_W (4) | Count value that marks a danger cycle |
| align_early | input | 1 | Toggle copy with the short external delay |
| align_late | input | 1 | Toggle copy with the long external delay |
| align_tgl | output | 1 | Transmit-domain toggle flop |
| dout | output | 1 | Synchronized data |
| sync_sel | output | 1 | 1 when the two-flop path drives `dout` |
| aligned | output | 1 | Counter has been restarted at least once since reset |

## Verification
With a 5:4 clock ratio, phase 0 and period 5, two events fall on the same receive edge: the sample disagreement that re-triggers alignment, and the counter's own return to the danger count. On that same edge, the transmit edge that the bench poisons with an unknown value is also captured. The bench therefore drives `tx_bit` unknown for a short window after each transmit edge. It derives the disagreement edges from the actual edge times. A timing-based model then predicts `sync_sel` and `dout`, including unknowns, and compares them with the design every cycle. A separate check requires `dout` to be known on every aligned cycle.

// File: rtl/psync_pkg.sv
`timescale 1ns/1ps
package psync_pkg;
    localparam int MIN_PERIOD = 2;

    typedef struct packed {
        logic early;
        logic late;
    } probe_t;
endpackage

// File: rtl/psync_cfg.sv
`timescale 1ns/1ps
module psync_cfg
    import psync_pkg::*;
#(
    parameter int MAX_PERIOD = 16,
    parameter int DEF_PERIOD = 4,
    localparam int CNT_W = $clog2(MAX_PERIOD),
    localparam int CFG_W = CNT_W + 1
) (
    input  logic [CFG_W-1:0] period_cfg,
    input  logic [CNT_W-1:0] phase_cfg,
    output logic [CNT_W-1:0] last_cnt,
    output logic [CNT_W-1:0] phase_eff
);
    logic [CFG_W-1:0] per;

    always_comb begin
        if (period_cfg == '0)
            per = CFG_W'(DEF_PERIOD);
        else if (period_cfg < CFG_W'(MIN_PERIOD))
            per = CFG_W'(MIN_PERIOD);
        else if (period_cfg > CFG_W'(MAX_PERIOD))
            per = CFG_W'(MAX_PERIOD);
        else
            per = period_cfg;
        last_cnt  = CNT_W'(per - 1'b1);
        phase_eff = (phase_cfg > last_cnt) ? last_cnt : phase_cfg;
    end
endmodule

// File: rtl/psync_phase_det.sv
`timescale 1ns/1ps
module psync_phase_det
    import psync_pkg::*;
(
    input  logic tx_clk,
    input  logic tx_rst_n,
    input  logic rx_clk,
    input  logic rx_rst_n,
    input  logic align_early,
    input  logic align_late,
    output logic align_tgl,
    output logic diff
);
    logic   tgl_d, tgl_q;
    probe_t smp_d, smp_q;

    always_comb begin
        tgl_d       = ~tgl_q;
        smp_d.early = align_early;
        smp_d.late  = align_late;
    end

    always_ff @(posedge tx_clk) begin
        if (!tx_rst_n) tgl_q <= 1'b0;
        else           tgl_q <= tgl_d;
    end

    always_ff @(posedge rx_clk) begin
        if (!rx_rst_n) smp_q <= '0;
        else           smp_q <= smp_d;
    end

    assign align_tgl = tgl_q;
    assign diff      = smp_q.early ^ smp_q.late;

    // R2: the transmit toggle inverts on every running edge
    p_toggle_r2: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        tx_rst_n |=> (tgl_q != $past(tgl_q)));
endmodule

// File: rtl/psync_predictor.sv
`timescale 1ns/1ps
module psync_predictor #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             align_en,
    input  logic             diff,
    input  logic [CNT_W-1:0] last_cnt,
    input  logic [CNT_W-1:0] phase_eff,
    output logic             danger,
    output logic             aligned
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             aligned;
        logic             danger;
    } pred_t;

    localparam pred_t PRED_RST = '{cnt: '0, aligned: 1'b0, danger: 1'b1};

    pred_t st_d, st_q;
    logic  restart;

    always_comb begin
        restart = align_en & diff;
        st_d    = st_q;
        if (restart) begin
            st_d.cnt     = CNT_W'(1);
            st_d.aligned = 1'b1;
        end else if (st_q.cnt >= last_cnt) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.danger = ~st_d.aligned | (st_d.cnt == phase_eff);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= PRED_RST;
        else        st_q <= st_d;
    end

    assign danger  = st_q.danger;
    assign aligned = st_q.aligned;

    // R2: a permitted disagreement restarts the count at 1 and marks alignment
    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (align_en && diff) |=> (st_q.cnt == CNT_W'(1) && st_q.aligned));
    // R2: alignment is sticky until reset
    p_aligned_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.aligned |=> st_q.aligned);
    // R3: the count wraps once it has reached the last value
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt >= last_cnt && !(align_en && diff)) |=> (st_q.cnt == '0));
    // R10: with alignment disabled the count only steps forward
    p_free_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!align_en && st_q.cnt < last_cnt) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));
    // R8: reset clears the prediction state
    p_reset_r8: assert property (@(posedge clk)
        !rst_n |=> (st_q.cnt == '0 && !st_q.aligned && st_q.danger));
endmodule

// File: rtl/psync_datapath.sv
`timescale 1ns/1ps
module psync_datapath (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic use_sync,
    output logic dout
);
    typedef struct packed {
        logic s1;
        logic s2;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d.s1 = din;
        cap_d.s2 = cap_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign dout = use_sync ? cap_q.s2 : cap_q.s1;

    // R4: a fast-path cycle shows the value sampled at the latest edge
    p_fast_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !use_sync) |-> (dout === $past(din)));
    // R5: a danger cycle shows the value sampled one edge before
    p_sync_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && use_sync) |-> (dout === $past(din, 2)));
endmodule

// File: rtl/predictive_sync.sv
`timescale 1ns/1ps
module predictive_sync #(
    parameter int MAX_PERIOD = 16,
    parameter int DEF_PERIOD = 4,
    localparam int CNT_W = $clog2(MAX_PERIOD),
    localparam int CFG_W = CNT_W + 1
) (
    input  logic             rx_clk,
    input  logic             rx_rst_n,
    input  logic             tx_clk,
    input  logic             tx_rst_n,
    input  logic             tx_bit,
    input  logic             align_en,
    input  logic [CFG_W-1:0] period_cfg,
    input  logic [CNT_W-1:0] phase_cfg,
    input  logic             align_early,
    input  logic             align_late,
    output logic             align_tgl,
    output logic             dout,
    output logic             sync_sel,
    output logic             aligned
);
    logic [CNT_W-1:0] last_cnt;
    logic [CNT_W-1:0] phase_eff;
    logic             diff;

    psync_cfg #(
        .MAX_PERIOD (MAX_PERIOD),
        .DEF_PERIOD (DEF_PERIOD)
    ) u_cfg (
        .period_cfg (period_cfg),
        .phase_cfg  (phase_cfg),
        .last_cnt   (last_cnt),
        .phase_eff  (phase_eff)
    );

    psync_phase_det u_det (
        .tx_clk      (tx_clk),
        .tx_rst_n    (tx_rst_n),
        .rx_clk      (rx_clk),
        .rx_rst_n    (rx_rst_n),
        .align_early (align_early),
        .align_late  (align_late),
        .align_tgl   (align_tgl),
        .diff        (diff)
    );

    psync_predictor #(
        .CNT_W (CNT_W)
    ) u_pred (
        .clk       (rx_clk),
        .rst_n     (rx_rst_n),
        .align_en  (align_en),
        .diff      (diff),
        .last_cnt  (last_cnt),
        .phase_eff (phase_eff),
        .danger    (sync_sel),
        .aligned   (aligned)
    );

    psync_datapath u_dp (
        .clk      (rx_clk),
        .rst_n    (rx_rst_n),
        .din      (tx_bit),
        .use_sync (sync_sel),
        .dout     (dout)
    );

    // R1: no fast-path cycle before alignment
    p_unaligned_safe_r1: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        (!aligned && $past(rx_rst_n)) |-> $past(sync_sel) || $past(aligned));
endmodule

// File: tb/tb_predictive_sync.sv
`timescale 1ns/100ps
module tb_predictive_sync;
    localparam int CW = 5;
    localparam int NW = 4;

    logic          rx_clk = 1'b0, tx_clk = 1'b0;
    logic          rx_rst_n = 1'b0, tx_rst_n = 1'b0;
    logic          tx_bit = 1'b0, align_en = 1'b0;
    logic [CW-1:0] period_cfg = CW'(5);
    logic [NW-1:0] phase_cfg = '0;
    logic          align_early = 1'b0, align_late = 1'b0;
    logic          align_tgl, dout, sync_sel, aligned;

    int    checks = 0, errors = 0;
    bit    xinj = 1'b1, xguard = 1'b0, started = 1'b0;
    string sel_tag = "R3";

    realtime last_tx = -100.0;
    bit      last_chg = 1'b0;
    logic    m_tgl = 1'b0;
    int      m_cnt = 0;
    bit      m_al = 1'b0, m_sel = 1'b1, m_diff = 1'b0, m_inrst = 1'b1;
    logic    m_s1 = 1'b0, m_s2 = 1'b0;

    predictive_sync dut (
        .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .tx_clk(tx_clk), .tx_rst_n(tx_rst_n),
        .tx_bit(tx_bit), .align_en(align_en), .period_cfg(period_cfg),
        .phase_cfg(phase_cfg), .align_early(align_early), .align_late(align_late),
        .align_tgl(align_tgl), .dout(dout), .sync_sel(sync_sel), .aligned(aligned)
    );

    // receive clock: 125 MHz, rising edges at 6 + 8k ns
    initial begin
        #6;
        forever begin rx_clk = 1'b1; #4; rx_clk = 1'b0; #4; end
    end
    // transmit clock: 10 ns, rising edges at 5 + 10m ns (5:4 period ratio)
    initial forever begin #5; tx_clk = ~tx_clk; end
    initial begin #22; tx_rst_n = 1'b1; end

    // external delay elements forming the two sampling points
    always @(align_tgl) begin #0.5; align_early = align_tgl; end
    always @(align_tgl) begin #2.5; align_late  = align_tgl; end

    // transmit data: unknown briefly after each edge, then a random value
    always @(posedge tx_clk) begin
        if (xinj) tx_bit = 1'bx;
        #1.5;
        tx_bit = 1'($urandom_range(0, 1));
    end

    always @(posedge tx_clk) begin
        last_tx  = $realtime;
        last_chg = tx_rst_n;
        m_tgl    = tx_rst_n ? ~m_tgl : 1'b0;
    end

    function automatic int eff_period(int code);
        if (code == 0) return 4;
        if (code < 2) return 2;
        if (code > 16) return 16;
        return code;
    endfunction

    task automatic check_bit(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // behavioural reference driven by edge times
    always @(posedge rx_clk) begin
        automatic int  p   = eff_period(int'(period_cfg));
        automatic int  ph  = (int'(phase_cfg) > p - 1) ? p - 1 : int'(phase_cfg);
        automatic real dt  = $realtime - last_tx;
        automatic bit  det = last_chg && dt >= 0.5 && dt < 2.5;
        if (!rx_rst_n) begin
            m_cnt = 0; m_al = 1'b0; m_s1 = 1'b0; m_s2 = 1'b0;
            m_diff = 1'b0; m_sel = 1'b1; m_inrst = 1'b1;
        end else begin
            m_inrst = 1'b0;
            if (m_diff && align_en) begin
                m_cnt = 1; m_al = 1'b1;
            end else begin
                m_cnt = (m_cnt >= p - 1) ? 0 : m_cnt + 1;
            end
            m_s2   = m_s1;
            m_s1   = tx_bit;
            m_sel  = !m_al || (m_cnt == ph);
            m_diff = det;
        end
        started = 1'b1;
    end

    always @(negedge rx_clk) begin
        if (started) begin
            check_bit(m_inrst ? "R8" : (m_sel ? "R5" : "R4"), "dout", dout, m_sel ? m_s2 : m_s1);
            check_bit(m_inrst ? "R8" : (!m_al ? "R1" : sel_tag), "sync_sel", sync_sel, m_sel);
            check_bit(m_inrst ? "R8" : "R2", "aligned", aligned, m_al);
            if (xguard && m_al) begin
                checks++;
                if ($isunknown(dout)) begin
                    errors++;
                    $display("FAIL R9 dout: actual %b expected known at %0t", dout, $time);
                end
            end
        end
    end

    always @(negedge tx_clk) begin
        if (last_tx > 0.0) check_bit("R2", "align_tgl", align_tgl, m_tgl);
    end

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge rx_clk);
        rx_rst_n = 1'b1;
        // R1: unaligned, always on the two-flop path
        repeat (20) @(negedge rx_clk);
        // R2, R3, R4, R5, R9: alignment on the true 5-cycle beat
        align_en = 1'b1; xguard = 1'b1;
        repeat (40) @(negedge rx_clk);
        // R3: shifted danger phase, clean data
        xguard = 1'b0; xinj = 1'b0; phase_cfg = NW'(2);
        repeat (30) @(negedge rx_clk);
        // R7: phase beyond the period
        sel_tag = "R7"; phase_cfg = NW'(15);
        repeat (20) @(negedge rx_clk);
        // R10: disagreements ignored, free-running count
        sel_tag = "R10"; align_en = 1'b0;
        repeat (20) @(negedge rx_clk);
        // R6: period code mapping
        sel_tag = "R6"; period_cfg = CW'(0);
        repeat (20) @(negedge rx_clk);
        period_cfg = CW'(1);
        repeat (20) @(negedge rx_clk);
        period_cfg = CW'(31);
        repeat (40) @(negedge rx_clk);
        // R8: mid-run reset, then realignment with poisoned data
        rx_rst_n = 1'b0;
        repeat (3) @(negedge rx_clk);
        rx_rst_n = 1'b1; period_cfg = CW'(5); phase_cfg = '0;
        xinj = 1'b1; align_en = 1'b1; sel_tag = "R3";
        repeat (10) @(negedge rx_clk);
        xguard = 1'b1;
        repeat (30) @(negedge rx_clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule